// File: doc/BRIEF.md
# SIMD Lane Permute and Extract Unit

This unit takes one 256-bit word that holds a typed vector and rearranges its elements under a second, integer-typed mask vector. It can also pull a single element out of the vector, selected by an index, and return that element zero-extended to the full word. Each operand carries an 8-bit type byte. The type byte states whether the elements are integer or floating point, the lane width as a power-of-two byte count, and the element count as a power of two. Element 0 sits in the least significant bits of the word.

A one-byte operation code chooses the function. Code 0xBF permutes. Code 0xBA extracts, and takes its index from element 0 of the mask vector. In a permute the mask may use a lane width different from the source, but it must have the same element count. Any mask value at or beyond the element count yields zero in that position. When the type bytes or the operation code are not acceptable, the unit raises an invalid flag and returns an all-zero word. The result and the flag are registered, so they appear one clock after the inputs.

Top module: `simd_permute_unit`

## Requirements
- R1: Type byte layout: bit 7 = float flag, bits 5:4 = log2 of lane bytes, bits 2:0 = log2 of element count, and bits 6 and 3 must be zero. A source type is legal only when those two bits are zero, the sum of the two log2 fields is at most 5, and a float source uses 4- or 8-byte lanes. An illegal source type sets the invalid flag.
- R2: With op code 0xBF, output element i is the source element whose number equals mask element i. Elements use the source lane width, and element 0 is in bits [W-1:0].
- R3: Mask elements are read as unsigned integers of the mask's own lane width, which may differ from the source lane width.
- R4: A mask type with bit 7 set (float), or a mask type that breaks the R1 layout rules, sets the invalid flag.
- R5: For op code 0xBF, a mask element count that differs from the source element count sets the invalid flag.
- R6: A permute mask value greater than or equal to the element count gives zero in that output element.
- R7: In a permute result, all bits above element count times lane width are zero.
- R8: With op code 0xBA, the result is the source element selected by mask element 0, zero-extended to 256 bits. The mask element count is not constrained.
- R9: An extract index greater than or equal to the element count gives an all-zero result without setting the invalid flag.
- R10: Any op code other than 0xBF and 0xBA sets the invalid flag.
- R11: Whenever the invalid flag is set, the result is all zero.
- R12: The result and flag are registered with one cycle of latency. A synchronous active-low reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 8 | Operation code (0xBF permute, 0xBA extract) |
| src_i | input | 256 | Source vector, element 0 in the low bits |
| src_type_i | input | 8 | Source type byte |
| mask_i | input | 256 | Mask vector, or index in element 0 for extract |
| mask_type_i | input | 8 | Mask type byte |
| result_o | output | 256 | Registered result |
| invalid_o | output | 1 | Registered invalid flag |

## Verification
The unit keeps no state beyond its output register. Any wrong decision therefore shows at the ports exactly one cycle after the offending inputs. A mis-decoded lane width or element count moves element boundaries, which scrambles whole lanes of the result. A wrong range comparison leaves stale data in lanes that should read zero, or clears lanes that should hold data. A wrong legality decision flips the invalid flag and zeroes a result that should be non-zero. Each applied vector is compared in full at the following cycle, so every such fault is caught on the first vector that exercises it.

// File: rtl/simd_perm_pkg.sv
// Shared constants, the decoded type record and a lane-field reader for the
// permute/extract unit. Assumes a fixed 256-bit vector word.
package simd_perm_pkg;

    localparam int WORD_W    = 256;
    localparam int MAX_LANE  = 64;

    typedef struct packed {
        logic [1:0] lw;     // log2 of lane width in bytes
        logic [2:0] ec;     // log2 of element count
        logic       legal;  // type byte acceptable for this operand
    } vtype_t;

    // Read element idx of a word whose lanes are (8 << lw) bits, zero-extended.
    function automatic logic [MAX_LANE-1:0] field_at(
        input logic [WORD_W-1:0] w,
        input int unsigned       idx,
        input logic [1:0]        lw
    );
        logic [WORD_W-1:0] sh;
        sh = w >> (idx << (3 + lw));
        case (lw)
            2'd0:    return {56'd0, sh[7:0]};
            2'd1:    return {48'd0, sh[15:0]};
            2'd2:    return {32'd0, sh[31:0]};
            default: return sh[63:0];
        endcase
    endfunction

endpackage

// File: rtl/simd_vtype_decode.sv
// Decodes one operand type byte into lane width, element count and a
// legality bit. ALLOW_FLOAT selects whether a float operand is acceptable
// (only with 4- or 8-byte lanes); reserved bits 6 and 3 must be zero.
module simd_vtype_decode
    import simd_perm_pkg::*;
#(
    parameter bit ALLOW_FLOAT = 1'b1
) (
    input  logic [7:0] type_i,
    output vtype_t     dec_o
);

    logic fp;
    logic fits;
    logic fp_ok;

    // Split fields and judge legality of the type byte.
    always_comb begin
        fp        = type_i[7];
        dec_o.lw  = type_i[5:4];
        dec_o.ec  = type_i[2:0];
        fits      = (4'(type_i[5:4]) + 4'(type_i[2:0])) <= 4'd5;
        fp_ok     = !fp || (ALLOW_FLOAT && type_i[5]);
        dec_o.legal = !type_i[6] && !type_i[3] && fits && fp_ok;
    end

endmodule

// File: rtl/simd_lane_permute.sv
// Builds the permuted word for every possible source lane width in parallel
// and picks the one matching the source type. Assumes mask and source have
// the same element count (checked by the caller); out-of-range mask values
// and lanes beyond the element count give zero.
module simd_lane_permute
    import simd_perm_pkg::*;
(
    input  logic [WORD_W-1:0] src_w,
    input  logic [1:0]        src_lw,
    input  logic [2:0]        src_ec,
    input  logic [WORD_W-1:0] mask_w,
    input  logic [1:0]        mask_lw,
    output logic [WORD_W-1:0] perm_w
);

    localparam int N_WIDTHS = 4;

    logic [6:0]        cnt;
    logic [WORD_W-1:0] cand [N_WIDTHS];

    assign cnt = 7'd1 << src_ec;

    // One candidate result per lane width, each lane picking its source.
    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int LW = 8 << g;
        localparam int N  = WORD_W / LW;
        localparam int IW = $clog2(N);
        logic [WORD_W-1:0] packed_w;
        for (genvar i = 0; i < N; i++) begin : g_lane
            logic [MAX_LANE-1:0] sel;
            assign sel = field_at(mask_w, i, mask_lw);
            assign packed_w[i*LW +: LW] =
                ((7'(i) < cnt) && (sel < {57'd0, cnt})) ? src_w[sel[IW-1:0]*LW +: LW] : '0;
        end
        assign cand[g] = packed_w;
    end

    assign perm_w = cand[src_lw];

endmodule

// File: rtl/simd_lane_extract.sv
// Returns the source element at a given index, zero-extended to the word.
// An index at or beyond the element count yields zero.
module simd_lane_extract
    import simd_perm_pkg::*;
(
    input  logic [WORD_W-1:0]   src_w,
    input  logic [1:0]          src_lw,
    input  logic [2:0]          src_ec,
    input  logic [MAX_LANE-1:0] index,
    output logic [WORD_W-1:0]   elem_w
);

    logic [6:0]        cnt;
    logic [10:0]       amt;
    logic [WORD_W-1:0] sh;

    // Shift the chosen element down and keep only its lane width.
    always_comb begin
        cnt    = 7'd1 << src_ec;
        amt    = 11'(index[4:0]) << (3 + src_lw);
        sh     = src_w >> amt;
        elem_w = '0;
        if (index < {57'd0, cnt}) begin
            case (src_lw)
                2'd0:    elem_w[7:0]  = sh[7:0];
                2'd1:    elem_w[15:0] = sh[15:0];
                2'd2:    elem_w[31:0] = sh[31:0];
                default: elem_w[63:0] = sh[63:0];
            endcase
        end
    end

endmodule

// File: rtl/simd_permute_unit.sv
// Top of the lane permute / extract unit. Decodes both type bytes, runs the
// permute and extract paths, judges validity and registers result and flag
// one cycle after the inputs. Synchronous active-low reset.
module simd_permute_unit
    import simd_perm_pkg::*;
#(
    parameter logic [7:0] PERMUTE_OP = 8'hBF,
    parameter logic [7:0] EXTRACT_OP = 8'hBA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        op_i,
    input  logic [WORD_W-1:0] src_i,
    input  logic [7:0]        src_type_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [7:0]        mask_type_i,
    output logic [WORD_W-1:0] result_o,
    output logic              invalid_o
);

    vtype_t              src_t;
    vtype_t              mask_t;
    logic [WORD_W-1:0]   perm_w;
    logic [WORD_W-1:0]   ext_w;
    logic [MAX_LANE-1:0] ext_idx;
    logic                is_perm;
    logic                is_ext;
    logic                next_inv;
    logic [WORD_W-1:0]   next_res;

    simd_vtype_decode #(.ALLOW_FLOAT(1'b1)) u_src_dec (
        .type_i (src_type_i),
        .dec_o  (src_t)
    );

    simd_vtype_decode #(.ALLOW_FLOAT(1'b0)) u_mask_dec (
        .type_i (mask_type_i),
        .dec_o  (mask_t)
    );

    simd_lane_permute u_perm (
        .src_w   (src_i),
        .src_lw  (src_t.lw),
        .src_ec  (src_t.ec),
        .mask_w  (mask_i),
        .mask_lw (mask_t.lw),
        .perm_w  (perm_w)
    );

    assign ext_idx = field_at(mask_i, 0, mask_t.lw);

    simd_lane_extract u_ext (
        .src_w  (src_i),
        .src_lw (src_t.lw),
        .src_ec (src_t.ec),
        .index  (ext_idx),
        .elem_w (ext_w)
    );

    // Decide validity and choose the path result.
    always_comb begin
        is_perm  = (op_i == PERMUTE_OP);
        is_ext   = (op_i == EXTRACT_OP);
        next_inv = !(is_perm || is_ext) || !src_t.legal || !mask_t.legal
                   || (is_perm && (mask_t.ec != src_t.ec));
        next_res = next_inv ? '0 : (is_perm ? perm_w : ext_w);
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            invalid_o <= 1'b0;
        end else begin
            result_o  <= next_res;
            invalid_o <= next_inv;
        end
    end

    p_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (result_o == '0));

    p_float_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_type_i[7] |=> invalid_o);

    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i != PERMUTE_OP) && (op_i != EXTRACT_OP)) |=> invalid_o);

    p_count_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == PERMUTE_OP) && (src_type_i[2:0] != mask_type_i[2:0])) |=> invalid_o);

    p_reserved_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_type_i[6] || src_type_i[3]) |=> invalid_o);

endmodule

// File: tb/simd_permute_unit_test.sv
// Self-checking bench: directed corner cases, then seeded random vectors,
// each compared with an independent reference model one cycle later.
module simd_permute_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   op_i = 8'h00;
    logic [255:0] src_i = '0;
    logic [7:0]   src_type_i = 8'h00;
    logic [255:0] mask_i = '0;
    logic [7:0]   mask_type_i = 8'h00;
    logic [255:0] result_o;
    logic         invalid_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    simd_permute_unit uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i),
        .src_type_i(src_type_i), .mask_i(mask_i), .mask_type_i(mask_type_i),
        .result_o(result_o), .invalid_o(invalid_o)
    );

    function automatic bit type_ok(input logic [7:0] t, input bit float_ok);
        int lw = t[5:4];
        int ec = t[2:0];
        if (t[6] || t[3]) return 0;
        if (lw + ec > 5) return 0;
        if (t[7] && (!float_ok || lw < 2)) return 0;
        return 1;
    endfunction

    function automatic longint unsigned elem(input logic [255:0] w, input int i, input int bits);
        longint unsigned v = 0;
        for (int b = 0; b < bits; b++) v[b] = w[i*bits + b];
        return v;
    endfunction

    // Reference model from the requirements.
    function automatic void model(input logic [7:0] op, input logic [7:0] st, input logic [255:0] sv,
                                  input logic [7:0] mt, input logic [255:0] mv,
                                  output logic [255:0] r, output logic inv);
        int sw = 8 << st[5:4];
        int mw = 8 << mt[5:4];
        int cnt = 1 << st[2:0];
        longint unsigned m;
        r = '0;
        inv = 1'b0;
        if (op != 8'hBF && op != 8'hBA) inv = 1'b1;
        if (!type_ok(st, 1) || !type_ok(mt, 0)) inv = 1'b1;
        if (op == 8'hBF && st[2:0] != mt[2:0]) inv = 1'b1;
        if (inv) return;
        if (op == 8'hBF) begin
            for (int i = 0; i < cnt; i++) begin
                m = elem(mv, i, mw);
                if (m < cnt)
                    for (int b = 0; b < sw; b++) r[i*sw + b] = sv[int'(m)*sw + b];
            end
        end else begin
            m = elem(mv, 0, mw);
            if (m < cnt)
                for (int b = 0; b < sw; b++) r[b] = sv[int'(m)*sw + b];
        end
    endfunction

    task automatic compare(input string tag, input logic [255:0] er, input logic ei);
        n_cmp++;
        if (result_o !== er || invalid_o !== ei) begin
            n_bad++;
            $display("FAIL %s: got result=%h invalid=%b expected result=%h invalid=%b",
                     tag, result_o, invalid_o, er, ei);
        end
    endtask

    task automatic run(input string tag, input logic [7:0] op, input logic [7:0] st,
                       input logic [255:0] sv, input logic [7:0] mt, input logic [255:0] mv);
        logic [255:0] er;
        logic ei;
        @(negedge clk);
        op_i = op; src_type_i = st; src_i = sv; mask_type_i = mt; mask_i = mv;
        model(op, st, sv, mt, mv, er, ei);
        @(negedge clk);
        compare(tag, er, ei);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] w;
        for (int k = 0; k < 8; k++) w[k*32 +: 32] = $urandom;
        return w;
    endfunction

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    localparam logic [255:0] EX_SRC = {64'd0, 64'd6, 64'd5, 64'd4};
    localparam logic [255:0] EX_OUT = {64'd0, 64'd5, 64'd4, 64'd6};

    initial begin
        void'($urandom(32'h5EED_1234));
        src_i = rnd256();
        mask_i = rnd256();
        op_i = 8'hBF; src_type_i = 8'h32; mask_type_i = 8'h02;
        repeat (3) @(negedge clk);
        compare("R12 reset clears outputs", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 worked example, checked against a literal as well.
        run("R2 example permute", 8'hBF, 8'h32, EX_SRC, 8'h02, 256'h03010002);
        compare("R2 literal", EX_OUT, 1'b0);
        // R12: one-cycle latency, new inputs reach output after one edge.
        run("R12 latency", 8'hBA, 8'h32, EX_SRC, 8'h00, 256'h2);
        compare("R8 extract literal", 256'd6, 1'b0);
        run("R3 wide mask narrow src", 8'hBF, 8'h02, 256'h44332211, 8'h22,
            {128'd0, 32'd0, 32'd3, 32'd1, 32'd2});
        run("R3 narrow mask wide src", 8'hBF, 8'h31, {128'd0, 64'hAAAA, 64'hBBBB}, 8'h01, 256'h0001);
        run("R4 float mask", 8'hBF, 8'h32, EX_SRC, 8'hA2, 256'h0);
        run("R4 mask reserved bit", 8'hBA, 8'h32, EX_SRC, 8'h40, 256'h0);
        run("R5 count mismatch", 8'hBF, 8'h32, EX_SRC, 8'h03, 256'h0);
        run("R6 mask value out of range", 8'hBF, 8'h32, EX_SRC, 8'h02, 256'h01C80004);
        run("R7 upper bits zero", 8'hBF, 8'h02, rnd256(), 8'h02, 256'h00010203);
        run("R8 extract float lane", 8'hBA, 8'hA3, rnd256(), 8'h30, 256'd5);
        run("R9 extract index out of range", 8'hBA, 8'h32, EX_SRC, 8'h00, 256'd9);
        run("R10 unknown op", 8'h01, 8'h32, EX_SRC, 8'h02, 256'h03010002);
        run("R1 oversize src type", 8'hBF, 8'h3F, rnd256(), 8'h07, 256'h0);
        run("R1 narrow float src", 8'hBF, 8'h81, rnd256(), 8'h01, 256'h0);
        run("R1 reserved src bit", 8'hBA, 8'h0A, rnd256(), 8'h00, 256'h0);
        run("R11 invalid gives zero", 8'hFF, 8'h05, rnd256(), 8'h05, rnd256());
        run("R2 full 32-lane permute", 8'hBF, 8'h05, rnd256(), 8'h05, rnd256() & {32{8'h1F}});

        // Seeded random mix of permute, extract and illegal cases.
        for (int n = 0; n < 600; n++) begin
            int kind = $urandom % 10;
            int slw = $urandom % 4;
            int sec = $urandom % (6 - slw);
            int mlw, mec, mw, cnt;
            bit sf = (slw >= 2) && ($urandom % 4 == 0);
            logic [7:0] op, st, mt;
            logic [255:0] mv = '0;
            op = (kind < 5) ? 8'hBF : (kind < 9) ? 8'hBA : 8'($urandom);
            if (op == 8'hBF) begin
                mlw = $urandom % (((5 - sec) < 3 ? (5 - sec) : 3) + 1);
                mec = sec;
            end else begin
                mlw = $urandom % 4;
                mec = $urandom % (6 - mlw);
            end
            st = {sf, 1'b0, 2'(slw), 1'b0, 3'(sec)};
            mt = {1'b0, 1'b0, 2'(mlw), 1'b0, 3'(mec)};
            if ($urandom % 16 == 0) st = 8'($urandom);
            if ($urandom % 16 == 0) mt = 8'($urandom);
            mw = 8 << mlw;
            cnt = 1 << sec;
            for (int i = 0; i < (256 / mw); i++) begin
                longint unsigned v = ($urandom % 4 != 0) ? longint'($urandom % cnt)
                                                         : {32'($urandom), 32'($urandom)};
                for (int b = 0; b < mw; b++) mv[i*mw + b] = v[b];
            end
            run("R2 R3 R6 R8 R9 random", op, st, rnd256(), mt, mv);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule